// File: doc/BRIEF.md
# Multithreaded Reorder Buffer with Oldest-Head Selection

This block keeps in-flight instructions in program order for several hardware threads at once. Each thread owns a first-in first-out queue of entries. All queues draw on one shared pool limit of `CAPACITY` entries. An entry holds a global sequence number (larger means younger), a ready flag and a squashed flag. One instruction can be inserted per cycle. One completion notice can mark an entry ready, and optionally squashed, by thread and sequence number. One retire request per cycle removes the front entry of a named thread, provided that entry is ready. The retired entry is reported on a committed-output strobe one cycle later.

Besides the per-thread fronts, the block keeps a global head register and a global tail register. The head names the oldest instruction across the enabled threads. The tail names the youngest. Both are rebuilt by comparing sequence numbers across the threads' queue fronts and backs whenever an entry retires. On an insert they take a cheap shortcut instead. Commit logic upstream uses the per-thread head-ready flags and a single commit-possible flag to decide which thread to retire from.

Top module: `mt_rob`

## Requirements
- R1: An accepted insert appends the entry at the back of its thread's queue and raises both the total count and that thread's count by one; retirement order within a thread is insertion order.
- R2: An accepted insert while the total count is zero (and no retire accepted that cycle) makes the global head valid with that entry's thread and sequence number on the next cycle; otherwise an insert-only cycle leaves the head unchanged.
- R3: After any cycle with an accepted insert and no accepted retire, the global tail is valid and names the inserted entry, whether or not its thread is enabled.
- R4: An insert is dropped with no effect on any count, head or tail when the total count equals `CAPACITY` or the thread number is not below `THREADS`.
- R5: A retire is accepted only when the named thread is non-empty and its front entry is ready; it removes that entry, lowers both counts by one, and on the next cycle pulses `ret_done` with the entry's thread and sequence number. A retire of an empty or non-ready thread does nothing.
- R6: After an accepted retire, the global head names the front entry with the lowest sequence number among enabled non-empty threads (ties to the lower thread number), or is invalid when there is none.
- R7: After an accepted retire, the global tail names the back entry with the highest sequence number among enabled non-empty threads, or is invalid when there is none.
- R8: `head_ready[t]` is 0 while thread t is empty and otherwise equals the ready flag of its front entry.
- R9: `commit_ok` is 1 exactly when some enabled thread has `head_ready` set.
- R10: A completion marks ready the entry of the named thread whose sequence number matches; with `cmp_squash` set it also marks it squashed, which is reported on `ret_done_squashed` when that entry retires; a completion that matches no entry changes nothing.
- R11: After reset all counts are zero, head and tail are invalid, `ret_done` is 0 and every `head_ready` bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| active | input | THREADS | Enabled-thread mask used for head/tail choice and commit_ok |
| ins_valid | input | 1 | Insert request |
| ins_tid | input | TID_W | Thread of the inserted entry |
| ins_seq | input | SEQ_W | Global sequence number of the inserted entry |
| cmp_valid | input | 1 | Completion notice |
| cmp_tid | input | TID_W | Thread of the completing entry |
| cmp_seq | input | SEQ_W | Sequence number of the completing entry |
| cmp_squash | input | 1 | Also mark the completing entry squashed |
| ret_valid | input | 1 | Retire request |
| ret_tid | input | TID_W | Thread whose front entry is to retire |
| head_ready | output | THREADS | Per-thread front entry ready |
| commit_ok | output | 1 | Some enabled thread can retire |
| total_count | output | CNT_W | Entries held across all threads |
| thread_count | output | THREADS*CNT_W | Per-thread entry counts, thread t at bits t*CNT_W upward |
| head_valid | output | 1 | Global head is valid |
| head_tid | output | TID_W | Thread of the global head |
| head_seq | output | SEQ_W | Sequence number of the global head |
| tail_valid | output | 1 | Global tail is valid |
| tail_tid | output | TID_W | Thread of the global tail |
| tail_seq | output | SEQ_W | Sequence number of the global tail |
| ret_done | output | 1 | Committed strobe, one cycle after an accepted retire |
| ret_done_tid | output | TID_W | Thread of the committed entry |
| ret_done_seq | output | SEQ_W | Sequence number of the committed entry |
| ret_done_squashed | output | 1 | Committed entry had been squashed |

## Verification
A directed opening fills the buffer round-robin across threads until it is full. This separates the insert-into-empty head shortcut from the ordinary tail update. It also shows whether a further insert and an out-of-range thread number are dropped. Retiring a non-ready front, and completing a sequence number that is not present, show whether ignored requests leave any trace. A phase with one thread disabled tells whether the head and tail rebuild and `commit_ok` honour the enabled mask rather than mere occupancy. Long random runs then mix inserts, completions (some squashing, some stale), retires and mask changes on the same cycles. These expose ordering faults in the circular queues after wraparound, and faults in the next-state views feeding the age comparison.

// File: rtl/mt_rob_pkg.sv
package mt_rob_pkg;

   // Which end of the age order a picker selects.
   typedef enum logic {
      PICK_OLDEST   = 1'b0,
      PICK_YOUNGEST = 1'b1
   } age_pick_e;

   // Width of an index able to address n items (at least one bit).
   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/rob_thread_fifo.sv
module rob_thread_fifo #(
   parameter int DEPTH = 16,
   parameter int SEQ_W = 16,
   localparam int IDX_W = mt_rob_pkg::idx_width(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [SEQ_W-1:0] push_seq,
   input  logic             pop,
   input  logic             mark,
   input  logic [SEQ_W-1:0] mark_seq,
   input  logic             mark_squash,
   output logic [CNT_W-1:0] count,
   output logic             nonempty,
   output logic [SEQ_W-1:0] front_seq,
   output logic             front_rdy,
   output logic             front_sqs,
   output logic [SEQ_W-1:0] back_seq,
   output logic             nx_nonempty,
   output logic [SEQ_W-1:0] nx_front_seq,
   output logic [SEQ_W-1:0] nx_back_seq
);

   logic [DEPTH-1:0][SEQ_W-1:0] seq_all;
   logic [DEPTH-1:0]            vld_all;
   logic [DEPTH-1:0]            rdy_all;
   logic [DEPTH-1:0]            sqs_all;
   logic [DEPTH-1:0]            hit;
   logic [IDX_W-1:0]            rd_q;
   logic [IDX_W-1:0]            wr_q;
   logic [CNT_W-1:0]            cnt_q;
   logic [CNT_W-1:0]            nx_cnt;
   logic [IDX_W-1:0]            back_idx;

   function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] i);
      return (i == IDX_W'(DEPTH - 1)) ? '0 : i + 1'b1;
   endfunction

   function automatic logic [IDX_W-1:0] back_of(input logic [IDX_W-1:0] i);
      return (i == '0) ? IDX_W'(DEPTH - 1) : i - 1'b1;
   endfunction

   // One storage slot per position of the circular queue.
   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [SEQ_W-1:0] s_seq;
      logic             s_vld;
      logic             s_rdy;
      logic             s_sqs;
      logic             s_wr;
      logic             s_rd;

      assign s_wr   = push && (wr_q == IDX_W'(i));
      assign s_rd   = pop && (rd_q == IDX_W'(i));
      assign hit[i] = mark && s_vld && (s_seq == mark_seq);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            s_seq <= '0;
            s_vld <= 1'b0;
            s_rdy <= 1'b0;
            s_sqs <= 1'b0;
         end else if (s_wr) begin
            s_seq <= push_seq;
            s_vld <= 1'b1;
            s_rdy <= 1'b0;
            s_sqs <= 1'b0;
         end else if (s_rd) begin
            s_vld <= 1'b0;
            s_rdy <= 1'b0;
            s_sqs <= 1'b0;
         end else if (hit[i]) begin
            s_rdy <= 1'b1;
            if (mark_squash) begin
               s_sqs <= 1'b1;
            end
         end
      end

      assign seq_all[i] = s_seq;
      assign vld_all[i] = s_vld;
      assign rdy_all[i] = s_rdy;
      assign sqs_all[i] = s_sqs;
   end

   assign nx_cnt = cnt_q + CNT_W'(push) - CNT_W'(pop);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push) begin
            wr_q <= bump(wr_q);
         end
         if (pop) begin
            rd_q <= bump(rd_q);
         end
         cnt_q <= nx_cnt;
      end
   end

   assign back_idx  = back_of(wr_q);
   assign count     = cnt_q;
   assign nonempty  = (cnt_q != '0);
   assign front_seq = seq_all[rd_q];
   assign front_rdy = vld_all[rd_q] && rdy_all[rd_q];
   assign front_sqs = sqs_all[rd_q];
   assign back_seq  = seq_all[back_idx];

   // Views of the queue ends as they will be after this edge.
   always_comb begin
      if (pop) begin
         nx_front_seq = (cnt_q > CNT_W'(1)) ? seq_all[bump(rd_q)] : push_seq;
      end else begin
         nx_front_seq = (cnt_q == '0) ? push_seq : seq_all[rd_q];
      end
      nx_back_seq = push ? push_seq : seq_all[back_idx];
      nx_nonempty = (nx_cnt != '0);
   end

endmodule

// File: rtl/rob_age_pick.sv
module rob_age_pick #(
   parameter int                    N     = 4,
   parameter int                    SEQ_W = 16,
   parameter int                    TID_W = 2,
   parameter mt_rob_pkg::age_pick_e MODE  = mt_rob_pkg::PICK_OLDEST
) (
   input  logic [N-1:0]            cand,
   input  logic [N-1:0][SEQ_W-1:0] seqs,
   output logic                    found,
   output logic [TID_W-1:0]        win_tid,
   output logic [SEQ_W-1:0]        win_seq
);

   // Strict comparison keeps the lower thread number on equal keys.
   if (MODE == mt_rob_pkg::PICK_OLDEST) begin : g_oldest
      always_comb begin
         found   = 1'b0;
         win_tid = '0;
         win_seq = '0;
         for (int i = 0; i < N; i++) begin
            if (cand[i] && (!found || (seqs[i] < win_seq))) begin
               found   = 1'b1;
               win_tid = TID_W'(i);
               win_seq = seqs[i];
            end
         end
      end
   end else begin : g_youngest
      always_comb begin
         found   = 1'b0;
         win_tid = '0;
         win_seq = '0;
         for (int i = 0; i < N; i++) begin
            if (cand[i] && (!found || (seqs[i] > win_seq))) begin
               found   = 1'b1;
               win_tid = TID_W'(i);
               win_seq = seqs[i];
            end
         end
      end
   end

endmodule

// File: rtl/mt_rob.sv
module mt_rob #(
   parameter int THREADS  = 4,
   parameter int CAPACITY = 16,
   parameter int SEQ_W    = 16,
   localparam int TID_W   = mt_rob_pkg::idx_width(THREADS),
   localparam int CNT_W   = $clog2(CAPACITY + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [THREADS-1:0]       active,
   input  logic                     ins_valid,
   input  logic [TID_W-1:0]         ins_tid,
   input  logic [SEQ_W-1:0]         ins_seq,
   input  logic                     cmp_valid,
   input  logic [TID_W-1:0]         cmp_tid,
   input  logic [SEQ_W-1:0]         cmp_seq,
   input  logic                     cmp_squash,
   input  logic                     ret_valid,
   input  logic [TID_W-1:0]         ret_tid,
   output logic [THREADS-1:0]       head_ready,
   output logic                     commit_ok,
   output logic [CNT_W-1:0]         total_count,
   output logic [THREADS*CNT_W-1:0] thread_count,
   output logic                     head_valid,
   output logic [TID_W-1:0]         head_tid,
   output logic [SEQ_W-1:0]         head_seq,
   output logic                     tail_valid,
   output logic [TID_W-1:0]         tail_tid,
   output logic [SEQ_W-1:0]         tail_seq,
   output logic                     ret_done,
   output logic [TID_W-1:0]         ret_done_tid,
   output logic [SEQ_W-1:0]         ret_done_seq,
   output logic                     ret_done_squashed
);

   // Elaboration-time parameter checks.
   if (THREADS < 1) begin : g_bad_threads
      $error("mt_rob: THREADS must be at least 1");
   end
   if (CAPACITY < 2) begin : g_bad_capacity
      $error("mt_rob: CAPACITY must be at least 2");
   end
   if (SEQ_W < 4) begin : g_bad_seq
      $error("mt_rob: SEQ_W must be at least 4");
   end

   logic [THREADS-1:0][SEQ_W-1:0] front_seq_all;
   logic [THREADS-1:0][SEQ_W-1:0] back_seq_all;
   logic [THREADS-1:0][SEQ_W-1:0] nx_front_all;
   logic [THREADS-1:0][SEQ_W-1:0] nx_back_all;
   logic [THREADS-1:0]            nonempty_all;
   logic [THREADS-1:0]            nx_nonempty_all;
   logic [THREADS-1:0]            front_rdy_all;
   logic [THREADS-1:0]            front_sqs_all;
   logic [THREADS-1:0]            pick_cand;

   logic             ins_tid_ok;
   logic             ret_tid_ok;
   logic             ins_ok;
   logic             ret_ok;
   logic [CNT_W-1:0] total_q;

   logic             old_found;
   logic [TID_W-1:0] old_tid;
   logic [SEQ_W-1:0] old_seq;
   logic             yng_found;
   logic [TID_W-1:0] yng_tid;
   logic [SEQ_W-1:0] yng_seq;

   assign ins_tid_ok = (32'(ins_tid) < THREADS);
   assign ret_tid_ok = (32'(ret_tid) < THREADS);
   assign ins_ok     = ins_valid && ins_tid_ok && (total_q != CNT_W'(CAPACITY));
   assign ret_ok     = ret_valid && ret_tid_ok && head_ready[ret_tid];

   // One queue per thread, each deep enough to hold the whole pool.
   for (genvar t = 0; t < THREADS; t++) begin : g_thr
      logic             push_t;
      logic             pop_t;
      logic             mark_t;
      logic [CNT_W-1:0] cnt_t;

      assign push_t = ins_ok && (ins_tid == TID_W'(t));
      assign pop_t  = ret_ok && (ret_tid == TID_W'(t));
      assign mark_t = cmp_valid && (cmp_tid == TID_W'(t));

      rob_thread_fifo #(
         .DEPTH (CAPACITY),
         .SEQ_W (SEQ_W)
      ) u_fifo (
         .clk          (clk),
         .rst_n        (rst_n),
         .push         (push_t),
         .push_seq     (ins_seq),
         .pop          (pop_t),
         .mark         (mark_t),
         .mark_seq     (cmp_seq),
         .mark_squash  (cmp_squash),
         .count        (cnt_t),
         .nonempty     (nonempty_all[t]),
         .front_seq    (front_seq_all[t]),
         .front_rdy    (front_rdy_all[t]),
         .front_sqs    (front_sqs_all[t]),
         .back_seq     (back_seq_all[t]),
         .nx_nonempty  (nx_nonempty_all[t]),
         .nx_front_seq (nx_front_all[t]),
         .nx_back_seq  (nx_back_all[t])
      );

      assign thread_count[t*CNT_W +: CNT_W] = cnt_t;
   end

   assign head_ready = nonempty_all & front_rdy_all;
   assign commit_ok  = |(head_ready & active);
   assign pick_cand  = nx_nonempty_all & active;

   rob_age_pick #(
      .N     (THREADS),
      .SEQ_W (SEQ_W),
      .TID_W (TID_W),
      .MODE  (mt_rob_pkg::PICK_OLDEST)
   ) u_pick_old (
      .cand    (pick_cand),
      .seqs    (nx_front_all),
      .found   (old_found),
      .win_tid (old_tid),
      .win_seq (old_seq)
   );

   rob_age_pick #(
      .N     (THREADS),
      .SEQ_W (SEQ_W),
      .TID_W (TID_W),
      .MODE  (mt_rob_pkg::PICK_YOUNGEST)
   ) u_pick_yng (
      .cand    (pick_cand),
      .seqs    (nx_back_all),
      .found   (yng_found),
      .win_tid (yng_tid),
      .win_seq (yng_seq)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         total_q <= '0;
      end else begin
         total_q <= total_q + CNT_W'(ins_ok) - CNT_W'(ret_ok);
      end
   end

   assign total_count = total_q;

   // Global head and tail: full rebuild on retire, shortcut on insert.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_valid <= 1'b0;
         head_tid   <= '0;
         head_seq   <= '0;
         tail_valid <= 1'b0;
         tail_tid   <= '0;
         tail_seq   <= '0;
      end else if (ret_ok) begin
         head_valid <= old_found;
         head_tid   <= old_tid;
         head_seq   <= old_seq;
         tail_valid <= yng_found;
         tail_tid   <= yng_tid;
         tail_seq   <= yng_seq;
      end else if (ins_ok) begin
         tail_valid <= 1'b1;
         tail_tid   <= ins_tid;
         tail_seq   <= ins_seq;
         if (total_q == '0) begin
            head_valid <= 1'b1;
            head_tid   <= ins_tid;
            head_seq   <= ins_seq;
         end
      end
   end

   // Committed-entry report, one cycle after the retire is accepted.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ret_done          <= 1'b0;
         ret_done_tid      <= '0;
         ret_done_seq      <= '0;
         ret_done_squashed <= 1'b0;
      end else begin
         ret_done <= ret_ok;
         if (ret_ok) begin
            ret_done_tid      <= ret_tid;
            ret_done_seq      <= front_seq_all[ret_tid];
            ret_done_squashed <= front_sqs_all[ret_tid];
         end
      end
   end

endmodule

// File: rtl/mt_rob_chk.sv
module mt_rob_chk #(
   parameter int THREADS  = 4,
   parameter int CAPACITY = 16,
   parameter int SEQ_W    = 16,
   localparam int TID_W   = mt_rob_pkg::idx_width(THREADS),
   localparam int CNT_W   = $clog2(CAPACITY + 1)
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [THREADS-1:0]       active,
   input logic                     ins_valid,
   input logic [TID_W-1:0]         ins_tid,
   input logic [SEQ_W-1:0]         ins_seq,
   input logic                     ret_valid,
   input logic [THREADS-1:0]       head_ready,
   input logic                     commit_ok,
   input logic [CNT_W-1:0]         total_count,
   input logic [THREADS*CNT_W-1:0] thread_count,
   input logic                     head_valid,
   input logic                     tail_valid,
   input logic [SEQ_W-1:0]         head_seq,
   input logic [SEQ_W-1:0]         tail_seq,
   input logic                     ret_done
);

   logic ins_take;
   assign ins_take = ins_valid && (32'(ins_tid) < THREADS) && (total_count != CNT_W'(CAPACITY));

   AST_TOTAL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      total_count <= CNT_W'(CAPACITY)); // R1

   AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (total_count == CNT_W'(CAPACITY) && ins_valid && !ret_valid) |=> $stable(total_count)); // R4

   AST_HEAD_ON_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_take && total_count == '0 && !ret_valid) |=> (head_valid && head_seq == $past(ins_seq))); // R2

   AST_TAIL_ON_INSERT: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_take && !ret_valid) |=> (tail_valid && tail_seq == $past(ins_seq))); // R3

   AST_RETIRE_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      ret_done |-> ($past(total_count) != '0)); // R5

   AST_EMPTY_NO_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
      (total_count == '0) |-> (!head_valid && !tail_valid)); // R6

   AST_COMMIT_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      commit_ok |-> (total_count != '0)); // R9

   for (genvar t = 0; t < THREADS; t++) begin : g_thr_chk
      AST_EMPTY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
         (thread_count[t*CNT_W +: CNT_W] == '0) |-> !head_ready[t]); // R8
   end

   logic unused_ok;
   assign unused_ok = ^active;

endmodule

bind mt_rob mt_rob_chk #(
   .THREADS  (THREADS),
   .CAPACITY (CAPACITY),
   .SEQ_W    (SEQ_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .active       (active),
   .ins_valid    (ins_valid),
   .ins_tid      (ins_tid),
   .ins_seq      (ins_seq),
   .ret_valid    (ret_valid),
   .head_ready   (head_ready),
   .commit_ok    (commit_ok),
   .total_count  (total_count),
   .thread_count (thread_count),
   .head_valid   (head_valid),
   .tail_valid   (tail_valid),
   .head_seq     (head_seq),
   .tail_seq     (tail_seq),
   .ret_done     (ret_done)
);

// File: tb/mt_rob_test.sv
`timescale 1ns/1ps
module mt_rob_test;

   localparam int NT    = 3;
   localparam int CAP   = 6;
   localparam int SW    = 16;
   localparam int TW    = 2;
   localparam int CW    = 3;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NT-1:0]   active = '1;
   logic            ins_valid = 1'b0;
   logic [TW-1:0]   ins_tid = '0;
   logic [SW-1:0]   ins_seq = '0;
   logic            cmp_valid = 1'b0;
   logic [TW-1:0]   cmp_tid = '0;
   logic [SW-1:0]   cmp_seq = '0;
   logic            cmp_squash = 1'b0;
   logic            ret_valid = 1'b0;
   logic [TW-1:0]   ret_tid = '0;
   logic [NT-1:0]   head_ready;
   logic            commit_ok;
   logic [CW-1:0]   total_count;
   logic [NT*CW-1:0] thread_count;
   logic            head_valid, tail_valid, ret_done, ret_done_squashed;
   logic [TW-1:0]   head_tid, tail_tid, ret_done_tid;
   logic [SW-1:0]   head_seq, tail_seq, ret_done_seq;

   always #2 clk = ~clk;

   mt_rob #(.THREADS(NT), .CAPACITY(CAP), .SEQ_W(SW)) uut (
      .clk(clk), .rst_n(rst_n), .active(active),
      .ins_valid(ins_valid), .ins_tid(ins_tid), .ins_seq(ins_seq),
      .cmp_valid(cmp_valid), .cmp_tid(cmp_tid), .cmp_seq(cmp_seq), .cmp_squash(cmp_squash),
      .ret_valid(ret_valid), .ret_tid(ret_tid),
      .head_ready(head_ready), .commit_ok(commit_ok),
      .total_count(total_count), .thread_count(thread_count),
      .head_valid(head_valid), .head_tid(head_tid), .head_seq(head_seq),
      .tail_valid(tail_valid), .tail_tid(tail_tid), .tail_seq(tail_seq),
      .ret_done(ret_done), .ret_done_tid(ret_done_tid),
      .ret_done_seq(ret_done_seq), .ret_done_squashed(ret_done_squashed)
   );

   int errors = 0;
   int checks = 0;
   bit finished = 0;

   // Reference model: index 0 of each thread row is the front.
   int          mcnt [NT];
   int unsigned mseq [NT][CAP];
   bit          mrdy [NT][CAP];
   bit          msq  [NT][CAP];
   int          mtotal;
   bit          e_hv, e_tv, e_rd, e_rsq;
   int          e_ht, e_tt, e_rt;
   int unsigned e_hs, e_ts, e_rs;
   int unsigned next_seq = 1;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      for (int t = 0; t < NT; t++) begin
         mcnt[t] = 0;
         for (int k = 0; k < CAP; k++) begin
            mseq[t][k] = 0; mrdy[t][k] = 0; msq[t][k] = 0;
         end
      end
      mtotal = 0; e_hv = 0; e_tv = 0; e_rd = 0; e_rsq = 0;
      e_ht = 0; e_tt = 0; e_rt = 0; e_hs = 0; e_ts = 0; e_rs = 0;
   endtask

   // One clock: drive at the falling edge, model the edge, check at the next falling edge.
   task automatic step(input bit iv, input int it, input bit cv, input int ct,
                       input int unsigned cs, input bit csq, input bit rv, input int rt);
      bit ins_ok, ret_ok, was_empty;
      string ctag, htag, ttag;
      int unsigned iseq;
      iseq       = next_seq;
      ins_valid  = iv;  ins_tid = TW'(it); ins_seq = SW'(iseq);
      cmp_valid  = cv;  cmp_tid = TW'(ct); cmp_seq = SW'(cs); cmp_squash = csq;
      ret_valid  = rv;  ret_tid = TW'(rt);
      if (iv) next_seq++;
      ins_ok    = iv && it < NT && mtotal != CAP;
      ret_ok    = rv && rt < NT && mcnt[rt] > 0 && mrdy[rt][0];
      was_empty = (mtotal == 0);
      e_rd = ret_ok;
      if (ret_ok) begin
         e_rt = rt; e_rs = mseq[rt][0]; e_rsq = msq[rt][0];
      end
      if (cv && ct < NT) begin
         for (int k = 0; k < mcnt[ct]; k++) begin
            if (mseq[ct][k] == cs) begin
               mrdy[ct][k] = 1;
               if (csq) msq[ct][k] = 1;
            end
         end
      end
      if (ret_ok) begin
         for (int k = 0; k < CAP - 1; k++) begin
            mseq[rt][k] = mseq[rt][k+1]; mrdy[rt][k] = mrdy[rt][k+1]; msq[rt][k] = msq[rt][k+1];
         end
         mcnt[rt]--; mtotal--;
      end
      if (ins_ok) begin
         mseq[it][mcnt[it]] = iseq; mrdy[it][mcnt[it]] = 0; msq[it][mcnt[it]] = 0;
         mcnt[it]++; mtotal++;
      end
      if (ret_ok) begin
         e_hv = 0; e_tv = 0;
         for (int t = 0; t < NT; t++) begin
            if (active[t] && mcnt[t] > 0) begin
               if (!e_hv || mseq[t][0] < e_hs) begin e_hv = 1; e_ht = t; e_hs = mseq[t][0]; end
               if (!e_tv || mseq[t][mcnt[t]-1] > e_ts) begin e_tv = 1; e_tt = t; e_ts = mseq[t][mcnt[t]-1]; end
            end
         end
      end else if (ins_ok) begin
         e_tv = 1; e_tt = it; e_ts = iseq;
         if (was_empty) begin e_hv = 1; e_ht = it; e_hs = iseq; end
      end
      ctag = (iv && !ins_ok) ? "R4 dropped insert" : "R1 count";
      htag = ret_ok ? "R6 head rebuild" : "R2 head on insert";
      ttag = ret_ok ? "R7 tail rebuild" : "R3 tail on insert";
      @(posedge clk);
      @(negedge clk);
      ins_valid = 0; cmp_valid = 0; ret_valid = 0;
      chk(int'(total_count) == mtotal, {ctag, " total"}, total_count, mtotal);
      for (int t = 0; t < NT; t++) begin
         bit hr;
         chk(int'(thread_count[t*CW +: CW]) == mcnt[t], {ctag, " thread"}, thread_count[t*CW +: CW], mcnt[t]);
         hr = (mcnt[t] > 0) && mrdy[t][0];
         chk(head_ready[t] == hr, "R8 head_ready", head_ready[t], hr);
      end
      chk(head_valid == e_hv, {htag, " valid"}, head_valid, e_hv);
      if (e_hv) begin
         chk(int'(head_tid) == e_ht, {htag, " tid"}, head_tid, e_ht);
         chk(head_seq == SW'(e_hs), {htag, " seq"}, head_seq, e_hs);
      end
      chk(tail_valid == e_tv, {ttag, " valid"}, tail_valid, e_tv);
      if (e_tv) begin
         chk(int'(tail_tid) == e_tt, {ttag, " tid"}, tail_tid, e_tt);
         chk(tail_seq == SW'(e_ts), {ttag, " seq"}, tail_seq, e_ts);
      end
      chk(ret_done == e_rd, "R5 ret_done", ret_done, e_rd);
      if (e_rd) begin
         chk(int'(ret_done_tid) == e_rt, "R5 retired tid", ret_done_tid, e_rt);
         chk(ret_done_seq == SW'(e_rs), "R5 retired seq (R1 order)", ret_done_seq, e_rs);
         chk(ret_done_squashed == e_rsq, "R10 squashed flag", ret_done_squashed, e_rsq);
      end
      begin
         bit co;
         co = 0;
         for (int t = 0; t < NT; t++) co |= active[t] && mcnt[t] > 0 && mrdy[t][0];
         chk(commit_ok == co, "R9 commit_ok", commit_ok, co);
      end
   endtask

   task automatic idle();                    step(0,0,0,0,0,0,0,0); endtask
   task automatic ins(input int t);          step(1,t,0,0,0,0,0,0); endtask
   task automatic retire(input int t);       step(0,0,0,0,0,0,1,t); endtask
   task automatic mark_front(input int t, input bit sq);
      step(0,0,1,t,mseq[t][0],sq,0,0);
   endtask

   task automatic drain();
      for (int pass = 0; pass < 2 * CAP + 2; pass++) begin
         for (int t = 0; t < NT; t++) begin
            if (mcnt[t] > 0) begin
               mark_front(t, 0);
               retire(t);
            end
         end
      end
   endtask

   initial begin
      #(4 * 200000);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2718));
      model_reset();
      repeat (3) @(negedge clk);
      // R11: reset state
      chk(total_count == '0, "R11 total after reset", total_count, 0);
      chk(thread_count == '0, "R11 thread counts after reset", thread_count, 0);
      chk(!head_valid && !tail_valid, "R11 head/tail invalid", {head_valid, tail_valid}, 0);
      chk(!ret_done && head_ready == '0, "R11 ret_done/head_ready", {ret_done, head_ready}, 0);
      rst_n = 1'b1;
      idle();

      // Fill round-robin to capacity, then overfill.
      ins(1); ins(0); ins(2); ins(1); ins(0); ins(2);
      ins(0);                 // R4: full
      retire(1);              // R5: front not ready, ignored
      step(0,0,1,2,16'hBEEF,0,0,0); // R10: no matching entry
      mark_front(1, 1);       // R10: squash mark
      retire(1);              // R5/R10: squashed report
      ins(3);                 // R4: thread out of range
      ins(1);
      // Disabled thread 0: head rebuild must skip it (R6, R9).
      active = 3'b110;
      mark_front(0, 0);
      mark_front(2, 0);
      retire(2);
      retire(0);
      active = 3'b111;
      drain();
      idle();

      // Random mix.
      for (int n = 0; n < 4000; n++) begin
         bit iv, cv, csq, rv;
         int it, ct, rt;
         int unsigned cs;
         if (n % 60 == 59) begin
            active = NT'($urandom_range(1, (1 << NT) - 1));
         end
         iv  = ($urandom % 100) < 45;
         it  = $urandom % 4;
         cv  = ($urandom % 100) < 60;
         ct  = $urandom % NT;
         csq = ($urandom % 100) < 20;
         if (mcnt[ct] > 0 && ($urandom % 10) != 0) cs = mseq[ct][$urandom % mcnt[ct]];
         else cs = $urandom % 65536;
         rv  = ($urandom % 100) < 45;
         rt  = $urandom % NT;
         step(iv, it, cv, ct, cs, csq, rv, rt);
      end
      active = '1;
      drain();
      idle();

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule